// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Sequencer

The sequencer moves a block of bytes from one memory region to another while the processor stays off the bus. Software puts a source address, a destination address, two page values and a byte count on the inputs, then pulses `start_i`. The block raises a bus request and waits for the grant. It then moves each byte in two bus cycles. The first is a read from the source into an internal 8-bit holding register. The second is a write of that register to the destination.

Channel 0 carries the source address. Channel 1 carries the destination address and the remaining byte count. Each channel has a 16-bit address counter and a page value above it. The page value is latched at start and never changes during the copy. When a 16-bit counter wraps, the address stays in the same 64 KiB page. The page width sets the reach of the address: 4 page bits give a 20-bit address and 8 page bits give a 24-bit address.

The copy ends when the remaining count reaches zero, or earlier when the external stop input is raised. In both cases the block pulses `eop_o` and drops the bus request in that same cycle. A hold-source option keeps the source address fixed, so a single source byte fills the whole destination block.

Top module: `mem_copy_seq`

## Requirements
- R1: After reset, `hreq_o`, `mem_rd_o`, `mem_wr_o` and `eop_o` are low and `mem_addr_o` is zero.
- R2: A `start_i` pulse with a nonzero `count_i` raises `hreq_o` in the following cycle. No strobe is driven until `hgrant_i` is high.
- R3: Byte k (counting from 0) is read from `{src_page, src_addr + k}` and then written, unchanged, to `{dst_page, dst_addr + k}`. The page value occupies the top `PAGE_W` bits of `mem_addr_o`.
- R4: `mem_rd_o` and `mem_wr_o` are never high together. Each strobe lasts exactly one clock. `mem_addr_o` holds the same value in the cycle before each strobe. A byte takes four clocks.
- R5: Exactly `count_i` bytes are copied. After the final write, `eop_o` is high for one cycle, and `hreq_o` is low in that cycle.
- R6: The low 16 address bits wrap from 0xFFFF to 0x0000. The page bits stay the same.
- R7: When `hold_src_i` is high at start, every read uses the starting source address.
- R8: If `eop_i` is high during a copy, the byte in flight completes. No further read follows, and `eop_o` pulses once.
- R9: A `start_i` with `count_i` equal to zero is ignored. So is a `start_i` during a copy, and the inputs of the ignored start have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches the copy parameters |
| src_addr_i | input | 16 | Starting source address (channel 0) |
| src_page_i | input | PAGE_W | Source page bits |
| dst_addr_i | input | 16 | Starting destination address (channel 1) |
| dst_page_i | input | PAGE_W | Destination page bits |
| count_i | input | 16 | Number of bytes to copy |
| hold_src_i | input | 1 | Keep the source address fixed |
| eop_i | input | 1 | External stop request, active high |
| hreq_o | output | 1 | Bus request |
| hgrant_i | input | 1 | Bus grant |
| mem_addr_o | output | 16+PAGE_W | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Read data |
| mem_wdata_o | output | 8 | Write data |
| eop_o | output | 1 | End-of-process pulse |

## Verification
The bench sweeps byte counts from one to five, with the source held fixed and with it advancing, and with the grant given at once or after a delay. These runs separate a correct count from an off-by-one error, a stepping source from a held one, and strobes that wait for the grant from strobes that run ahead of it. The memory returns a byte computed from the address. Each written byte therefore shows which source address was read, and each write address shows how the destination counter has stepped. Runs whose start addresses sit just below 0xFFFF show whether a wrap carries into the page. Runs with an early stop and with a zero count show where the copy is cut short and whether an ignored start leaves any trace.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD_SET,
    ST_RD,
    ST_WR_SET,
    ST_WR,
    ST_DONE
  } mcs_state_e;
endpackage

// File: rtl/mcs_addr_ch.sv
module mcs_addr_ch #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  localparam int PA_W  = ADDR_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              step_i,
  output logic [PA_W-1:0]   addr_o
);
  logic [ADDR_W-1:0] lo_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      page_q <= '0;
    end else if (load_i) begin
      lo_q   <= base_i;
      page_q <= page_i;
    end else if (step_i) begin
      lo_q <= lo_q + 1'b1;  // wraps inside the page, no carry out
    end
  end

  assign addr_o = {page_q, lo_q};

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> page_q == $past(page_q)) else $error("page changed"); // R6
  AST_LO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && lo_q == '1) |=> lo_q == '0) else $error("no wrap"); // R6
endmodule

// File: rtl/mcs_word_cnt.sv
module mcs_word_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= count_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0) else $error("count underflow"); // R5
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic count_nz_i,
  input  logic hgrant_i,
  input  logic eop_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic cap_o,
  output logic addr_en_o,
  output logic sel_dst_o,
  output logic hreq_o,
  output logic rd_o,
  output logic wr_o,
  output logic eop_o
);
  mcs_state_e state_q, state_d;
  logic stop_q;
  logic finish;

  assign finish = last_i | stop_q | eop_i;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i && count_nz_i) begin
        state_d = ST_REQ;
        load_o  = 1'b1;
      end
      ST_REQ:    if (hgrant_i) state_d = ST_RD_SET;
      ST_RD_SET: state_d = ST_RD;
      ST_RD: begin
        cap_o   = 1'b1;
        state_d = ST_WR_SET;
      end
      ST_WR_SET: state_d = ST_WR;
      ST_WR: begin
        step_o  = 1'b1;
        state_d = finish ? ST_DONE : ST_RD_SET;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE || state_q == ST_DONE) stop_q <= 1'b0;
      else if (eop_i)                               stop_q <= 1'b1;
    end
  end

  assign hreq_o    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign rd_o      = (state_q == ST_RD);
  assign wr_o      = (state_q == ST_WR);
  assign eop_o     = (state_q == ST_DONE);
  assign sel_dst_o = (state_q == ST_WR_SET) || (state_q == ST_WR);
  assign addr_en_o = (state_q == ST_RD_SET) || (state_q == ST_RD) || sel_dst_o;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)) else $error("rd and wr together"); // R4
  AST_RD_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o) else $error("rd too long"); // R4
  AST_WR_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o) else $error("wr too long"); // R4
  AST_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> (hgrant_i && hreq_o)) else $error("strobe without grant"); // R2
  AST_EOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (!hreq_o && $past(wr_o))) else $error("eop not after write"); // R5
  AST_STOP_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && eop_i) |=> !rd_o) else $error("read after stop"); // R8
endmodule

// File: rtl/mem_copy_seq.sv
module mem_copy_seq #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int PA_W  = ADDR_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [PAGE_W-1:0] src_page_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [PAGE_W-1:0] dst_page_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              hold_src_i,
  input  logic              eop_i,
  output logic              hreq_o,
  input  logic              hgrant_i,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              eop_o
);
  logic load, step, cap, addr_en, sel_dst, last;
  logic hold_q;
  logic [DATA_W-1:0] tmp_q;
  logic [PA_W-1:0] src_addr, dst_addr;

  mcs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_nz_i (count_i != '0),
    .hgrant_i   (hgrant_i),
    .eop_i      (eop_i),
    .last_i     (last),
    .load_o     (load),
    .step_o     (step),
    .cap_o      (cap),
    .addr_en_o  (addr_en),
    .sel_dst_o  (sel_dst),
    .hreq_o     (hreq_o),
    .rd_o       (mem_rd_o),
    .wr_o       (mem_wr_o),
    .eop_o      (eop_o)
  );

  mcs_addr_ch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_src_ch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (src_addr_i),
    .page_i (src_page_i),
    .step_i (step && !hold_q),
    .addr_o (src_addr)
  );

  mcs_addr_ch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dst_ch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (dst_addr_i),
    .page_i (dst_page_i),
    .step_i (step),
    .addr_o (dst_addr)
  );

  mcs_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .count_i (count_i),
    .dec_i   (step),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      tmp_q  <= '0;
    end else begin
      if (load) hold_q <= hold_src_i;
      if (cap)  tmp_q  <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = !addr_en ? '0 : (sel_dst ? dst_addr : src_addr);
  assign mem_wdata_o = tmp_q;

  AST_ADDR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> $stable(mem_addr_o)) else $error("addr not set up"); // R4
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_wdata_o == $past(mem_rdata_i, 2)) else $error("data changed"); // R3
  AST_HOLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !load) |=> $stable(src_addr)) else $error("source moved"); // R7
endmodule

// File: tb/mem_copy_seq_test.sv
module mem_copy_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src_addr = '0, dst_addr = '0, count = '0;
  logic [3:0]  src_page = '0, dst_page = '0;
  logic        hold_src = 1'b0;
  logic        eop_in = 1'b0;
  logic        hgrant = 1'b0;
  logic        hreq, mem_rd, mem_wr, eop_out;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  mem_copy_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src_addr), .src_page_i(src_page),
    .dst_addr_i(dst_addr), .dst_page_i(dst_page),
    .count_i(count), .hold_src_i(hold_src), .eop_i(eop_in),
    .hreq_o(hreq), .hgrant_i(hgrant), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .eop_o(eop_out)
  );

  // monitor: cumulative records, never reset
  logic [19:0] rd_log [64];
  logic [19:0] wr_log [64];
  logic [7:0]  wd_log [64];
  int n_rd = 0, n_wr = 0, n_eop = 0, eop_hreq_bad = 0, viol = 0, setup_bad = 0;
  int stop_k = 0, wr_base = 0;
  logic [19:0] prev_addr = '0;

  always @(negedge clk) begin
    if (mem_rd && mem_wr) viol++;
    if ((mem_rd || mem_wr) && !hgrant) viol++;
    if ((mem_rd || mem_wr) && mem_addr != prev_addr) setup_bad++;
    if (mem_rd) begin rd_log[n_rd % 64] = mem_addr; n_rd++; end
    if (mem_wr) begin
      wr_log[n_wr % 64] = mem_addr;
      wd_log[n_wr % 64] = mem_wdata;
      n_wr++;
      if (stop_k > 0 && n_wr - wr_base == stop_k) eop_in = 1'b1;
    end
    if (eop_out) begin
      n_eop++;
      if (hreq) eop_hreq_bad++;
      eop_in = 1'b0;
    end
    prev_addr = mem_addr;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_copy(input logic [19:0] s, input logic [19:0] d, input int n,
                          input bit hold, input int stop_after, input int glat);
    int b_rd, b_wr, b_eop, b_viol, b_set, b_ehb, m, waited;
    b_rd = n_rd; b_wr = n_wr; b_eop = n_eop; b_viol = viol; b_set = setup_bad;
    b_ehb = eop_hreq_bad;
    wr_base = n_wr;
    stop_k = stop_after;
    m = (stop_after > 0 && stop_after < n) ? stop_after : n;
    @(negedge clk);
    src_addr = s[15:0]; src_page = s[19:16];
    dst_addr = d[15:0]; dst_page = d[19:16];
    count = 16'(n); hold_src = hold; start = 1'b1;
    @(negedge clk);
    check(hreq === 1'b1, "R2", "hreq after start", hreq, 1);
    // a second start while busy carries different values (R9)
    src_addr = ~s[15:0]; dst_addr = ~d[15:0]; count = 16'd9; hold_src = ~hold;
    @(negedge clk);
    start = 1'b0;
    repeat (glat) @(negedge clk);
    check(n_rd == b_rd && n_wr == b_wr, "R2", "strobes before grant", n_rd - b_rd, 0);
    hgrant = 1'b1;
    waited = 0;
    while (n_eop == b_eop && waited < 1000) begin @(negedge clk); waited++; end
    check(waited < 1000, "R5", "copy finished", waited, 0);
    hgrant = 1'b0;
    stop_k = 0;
    repeat (3) @(negedge clk);
    check(n_rd - b_rd == m, stop_after > 0 ? "R8" : "R5", "read count", n_rd - b_rd, m);
    check(n_wr - b_wr == m, stop_after > 0 ? "R8" : "R5", "write count", n_wr - b_wr, m);
    check(n_eop - b_eop == 1, "R5", "eop pulses", n_eop - b_eop, 1);
    check(eop_hreq_bad == b_ehb && hreq === 1'b0, "R5", "bus released at eop",
          eop_hreq_bad - b_ehb, 0);
    check(viol == b_viol, "R4", "strobe overlap or no grant", viol - b_viol, 0);
    check(setup_bad == b_set, "R4", "address setup", setup_bad - b_set, 0);
    for (int k = 0; k < m && k < 64; k++) begin
      logic [19:0] es, ed;
      es = hold ? s : {s[19:16], 16'(s[15:0] + 16'(k))};
      ed = {d[19:16], 16'(d[15:0] + 16'(k))};
      check(rd_log[(b_rd + k) % 64] == es, hold ? "R7" : "R3", "read address",
            rd_log[(b_rd + k) % 64], es);
      check(wr_log[(b_wr + k) % 64] == ed, "R3", "write address",
            wr_log[(b_wr + k) % 64], ed);
      check(wd_log[(b_wr + k) % 64] == pat(es), "R3", "write data",
            wd_log[(b_wr + k) % 64], pat(es));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hreq === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0 && eop_out === 1'b0,
          "R1", "idle outputs", {hreq, mem_rd, mem_wr, eop_out}, 0);
    check(mem_addr === 20'h0, "R1", "idle address", mem_addr, 0);

    // main sweep: count x hold x grant latency
    for (int n = 1; n <= 5; n++)
      for (int h = 0; h < 2; h++)
        for (int g = 0; g < 2; g++)
          run_copy(20'h21000 + 20'(n * 37), 20'h7C400 + 20'(n * 11), n, h[0], 0, g * 3);

    // R6 wrap inside page, both channels
    run_copy(20'h3FFFE, 20'hAFFFF, 4, 1'b0, 0, 1);
    run_copy(20'h9FFFF, 20'h5FFFD, 5, 1'b1, 0, 0);
    check(wr_log[(n_wr - 1) % 64] == 20'h50001, "R6", "wrapped dst stays in page",
          wr_log[(n_wr - 1) % 64], 20'h50001);

    // R8 early stop
    run_copy(20'h01234, 20'h04321, 6, 1'b0, 2, 0);
    run_copy(20'h0ABCD, 20'h0DCBA, 5, 1'b1, 1, 2);
    run_copy(20'hE0010, 20'hF0020, 4, 1'b0, 3, 1);

    // R9 zero count ignored
    begin
      int b;
      b = n_rd;
      @(negedge clk);
      count = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      hgrant = 1'b1;
      repeat (8) @(negedge clk);
      check(hreq === 1'b0, "R9", "zero count no request", hreq, 0);
      check(n_rd == b && eop_out === 1'b0, "R9", "zero count no cycle", n_rd - b, 0);
      hgrant = 1'b0;
    end
    // idle after all copies
    run_copy(20'h00000, 20'h00100, 3, 1'b0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule